// File: doc/BRIEF.md
# Double-Buffered Serial Front End for a 16-Bit DAC

This block is the digital side of a voltage-output converter. A host sends a serial word while chip select is low. The word goes into a shift register and, when the frame closes, into an input register. A separate active-low load strobe then moves the input register into the DAC latch. The latch code is what the converter sees. Because of this double buffering, several converters can be written one after another and then updated together.

The serial output has two selectable sources. In stand-alone mode it reads back the input register. In daisy-chain mode it passes the shift register through, so the next device in a chain receives the bits a frame later. Incoming words can be straight binary or two's complement. Two's complement words are mapped to straight binary before they are stored. A hardware reset loads a selectable value, either mid-scale or zero, into both registers. The power-down and gain selections are passed to the analog side as flags.

All pins are synchronised to the system clock `clk`. Serial-clock edges are detected by oversampling, so `sclk` must be slower than `clk`.

Top module: `serial_dac_frontend`

## Requirements
- R1: While `csn` is high, `sdo` is high impedance (`z`).
- R2: Bits are taken MSB first, one per falling `sclk` edge, and only while `csn` is low. In stand-alone mode (`sdo_src_sel`=1), a rising `csn` copies the word into the input register only if exactly 16 falling edges occurred. A frame of 15 or 17 edges leaves the input register unchanged.
- R3: In daisy-chain mode (`sdo_src_sel`=0), a frame of 16 or more falling edges commits the last 16 bits received.
- R4: With `fmt_sel`=1 the word is stored unchanged (straight binary). With `fmt_sel`=0 it is read as two's complement and stored with bit 15 inverted: 0x0000→0x8000, 0x7FFF→0xFFFF, 0x8000→0x0000, 0xA5A5→0x25A5.
- R5: While `ldac_n` is high, `dac_code` holds its value. While `ldac_n` is low, `dac_code` follows the input register.
- R6: While `rst_n` is low, the input register and `dac_code` take 0x8000 if `rst_sel`=1 and 0x0000 if `rst_sel`=0.
- R7: In stand-alone mode, `sdo` presents bit 15 of the input register after `csn` falls. It moves to the next lower bit after each rising `sclk` edge.
- R8: In daisy-chain mode, `sdo` repeats each received bit 16 `sclk` periods later. In a 32-bit frame, the bits seen before falling edges 17 to 32 are the first 16 bits sent.
- R9: `pwr_down` follows `pd` (1 = powered down), and `gain_x2` follows `gain_sel` (1 = gain of 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| rst_sel | input | 1 | Reset value select: 1 = 0x8000, 0 = 0x0000 |
| csn | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, `z` while `csn` is high |
| sdo_src_sel | input | 1 | 1 = read back input register, 0 = daisy chain |
| fmt_sel | input | 1 | 1 = straight binary, 0 = two's complement |
| ldac_n | input | 1 | Load strobe, active low; latch transparent while low |
| pd | input | 1 | Power-down request, active high |
| gain_sel | input | 1 | Gain select: 0 = x1, 1 = x2 |
| dac_code | output | 16 | DAC latch code (straight binary) |
| gain_x2 | output | 1 | Gain flag for the output stage |
| pwr_down | output | 1 | Power-down flag for the output stage |

## Verification
The assertions assume that `sclk` idles high and that every `sclk` level lasts several `clk` cycles. They also assume that `sdi`, `fmt_sel` and `sdo_src_sel` are stable around each detected edge, and that `rst_n` is driven low from time zero. The bench keeps to these assumptions. It holds each `sclk` level for six cycles, changes `sdi` only on rising `sclk`, and changes the mode selects only while `csn` is high. Reset is applied for ten cycles at the start, and again with each `rst_sel` value.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   // Map an incoming word to the straight-binary code held internally.
   function automatic logic [63:0] sdf_to_offset(input logic [63:0] w, input int unsigned width,
                                                 input logic straight);
      logic [63:0] r;
      r = w;
      if (!straight) r[width-1] = ~w[width-1];
      return r;
   endfunction
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
   parameter int unsigned N      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("sdf_sync: N must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [N-1:0] st [STAGES];
      always_ff @(posedge clk) begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              standalone_s,
   input  logic [DATA_W-1:0] rb_word,
   output logic [DATA_W-1:0] sh_word,
   output logic              commit,
   output logic              tx_msb
);
   localparam int unsigned CMAX  = DATA_W + 1;
   localparam int unsigned CNT_W = $clog2(CMAX + 1);

   if (DATA_W < 2) begin : g_bad_w
      $error("sdf_shifter: DATA_W must be at least 2");
   end

   logic              csn_q, sclk_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh, tx;
   logic              csn_fall, csn_rise, sclk_fall, sclk_rise, len_ok;

   assign csn_fall  = csn_q & ~csn_s;
   assign csn_rise  = ~csn_q & csn_s;
   assign sclk_fall = sclk_q & ~sclk_s;
   assign sclk_rise = ~sclk_q & sclk_s;
   assign len_ok    = standalone_s ? (cnt == CNT_W'(DATA_W)) : (cnt >= CNT_W'(DATA_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csn_q  <= 1'b1;
         sclk_q <= 1'b1;
         cnt    <= '0;
         sh     <= '0;
         tx     <= '0;
      end else begin
         csn_q  <= csn_s;
         sclk_q <= sclk_s;
         if (csn_fall) begin
            cnt <= '0;
            tx  <= standalone_s ? rb_word : sh;
         end else if (!csn_s) begin
            if (sclk_fall) begin
               sh <= {sh[DATA_W-2:0], sdi_s};
               if (cnt != CNT_W'(CMAX)) cnt <= cnt + 1'b1;
            end
            if (sclk_rise) tx <= standalone_s ? {tx[DATA_W-2:0], 1'b0} : sh;
         end
      end
   end

   assign sh_word = sh;
   assign commit  = csn_rise & len_ok;
   assign tx_msb  = tx[DATA_W-1];

   // R2: no serial bit is taken while chip select stays high
   assert_sh_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && $past(csn_s) && $past(rst_n)) |=> $stable(sh));
endmodule

// File: rtl/sdf_regs.sv
module sdf_regs
   import sdf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_sel_s,
   input  logic              fmt_s,
   input  logic              ldac_n_s,
   input  logic              commit,
   input  logic [DATA_W-1:0] sh_word,
   output logic [DATA_W-1:0] in_q,
   output logic [DATA_W-1:0] latch_q
);
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   if (DATA_W > 64) begin : g_bad_w
      $error("sdf_regs: DATA_W above 64 not supported");
   end

   logic [DATA_W-1:0] rst_val, conv;
   logic [63:0]       conv_wide;

   assign rst_val   = rst_sel_s ? MID : '0;
   assign conv_wide = sdf_to_offset(64'(sh_word), DATA_W, fmt_s);
   assign conv      = conv_wide[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q    <= rst_val;
         latch_q <= rst_val;
      end else begin
         if (commit)    in_q    <= conv;
         if (!ldac_n_s) latch_q <= in_q;
      end
   end

   logic rst_seen_q = 1'b0;
   always_ff @(posedge clk) if (!rst_n) rst_seen_q <= 1'b1;

   // R6: reset loads the selected value into both stages
   assert_reset_value_R6 : assert property (@(posedge clk)
      (rst_seen_q && !$past(rst_n)) |-> (in_q == $past(rst_val) && latch_q == $past(rst_val)));

   // R2: the input register changes only after a valid frame
   assert_inreg_commit_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(in_q)) |-> $past(commit));

   // R5: latch holds while the load strobe is high
   assert_latch_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ldac_n_s)) |-> $stable(latch_q));

   // R5: latch follows the input register while the strobe is low
   assert_latch_follow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ldac_n_s)) |-> (latch_q == $past(in_q)));
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_sel,
   input  logic              csn,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   input  logic              sdo_src_sel,
   input  logic              fmt_sel,
   input  logic              ldac_n,
   input  logic              pd,
   input  logic              gain_sel,
   output logic [DATA_W-1:0] dac_code,
   output logic              gain_x2,
   output logic              pwr_down
);
   localparam int unsigned NSYNC = 9;

   logic [NSYNC-1:0]  raw, syn;
   logic              csn_s, sclk_s, sdi_s, src_s, fmt_s, ldac_s, pd_s, gain_s, rsel_s;
   logic [DATA_W-1:0] in_q, sh_word;
   logic              commit, tx_msb;

   assign raw = {rst_sel, gain_sel, pd, ldac_n, fmt_sel, sdo_src_sel, sdi, sclk, csn};

   sdf_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (.clk(clk), .d(raw), .q(syn));

   assign {rsel_s, gain_s, pd_s, ldac_s, fmt_s, src_s, sdi_s, sclk_s, csn_s} = syn;

   sdf_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
      .standalone_s(src_s), .rb_word(in_q), .sh_word(sh_word),
      .commit(commit), .tx_msb(tx_msb)
   );

   sdf_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rst_sel_s(rsel_s), .fmt_s(fmt_s), .ldac_n_s(ldac_s),
      .commit(commit), .sh_word(sh_word), .in_q(in_q), .latch_q(dac_code)
   );

   assign sdo      = csn_s ? 1'bz : tx_msb;
   assign gain_x2  = gain_s;
   assign pwr_down = pd_s;
endmodule

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;
   localparam int H = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0, rst_sel = 1'b0, csn = 1'b1, sclk = 1'b1, sdi = 1'b0;
   logic        sdo_src_sel = 1'b1, fmt_sel = 1'b1, ldac_n = 1'b0, pd = 1'b0, gain_sel = 1'b0;
   wire         sdo;
   logic [15:0] dac_code;
   logic        gain_x2, pwr_down;

   serial_dac_frontend dut (
      .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .csn(csn), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_src_sel(sdo_src_sel), .fmt_sel(fmt_sel), .ldac_n(ldac_n), .pd(pd),
      .gain_sel(gain_sel), .dac_code(dac_code), .gain_x2(gain_x2), .pwr_down(pwr_down)
   );

   typedef struct packed { logic fmt; logic [15:0] word; logic [15:0] exp; } vec_t;
   localparam vec_t VECS [7] = '{
      '{1'b1, 16'h1234, 16'h1234}, '{1'b0, 16'h0000, 16'h8000},
      '{1'b0, 16'h7FFF, 16'hFFFF}, '{1'b0, 16'h8000, 16'h0000},
      '{1'b1, 16'hFFFF, 16'hFFFF}, '{1'b0, 16'hA5A5, 16'h25A5},
      '{1'b1, 16'h0001, 16'h0001}
   };

   int n_chk = 0, n_fail = 0;
   logic done = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic [31:0] data, input int n, output logic [31:0] got);
      got = '0;
      csn = 1'b0;
      wait_c(H);
      for (int i = 0; i < n; i++) begin
         sdi = data[31-i];
         wait_c(H);
         got[31-i] = sdo;
         sclk = 1'b0;
         wait_c(H);
         sclk = 1'b1;
      end
      wait_c(H);
      csn = 1'b1;
      wait_c(2*H);
   endtask

   task automatic do_reset(input logic sel);
      rst_sel = sel;
      rst_n   = 1'b0;
      wait_c(10);
      rst_n = 1'b1;
      wait_c(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      logic [15:0] prev;

      // R6: reset values
      wait_c(10);
      do_reset(1'b0);
      check("R6 reset zero", 32'(dac_code), 32'h0000);
      do_reset(1'b1);
      check("R6 reset mid", 32'(dac_code), 32'h8000);
      // R1: idle output
      n_chk++;
      if (sdo !== 1'bz) begin n_fail++; $display("FAIL R1 actual=%b expected=z", sdo); end
      // R9: flags
      pd = 1'b1; gain_sel = 1'b1; wait_c(4);
      check("R9 flags on", {30'd0, pwr_down, gain_x2}, 32'd3);
      pd = 1'b0; gain_sel = 1'b0; wait_c(4);
      check("R9 flags off", {30'd0, pwr_down, gain_x2}, 32'd0);

      // R2 R4 R7: vector walk in stand-alone mode
      prev = 16'h8000;
      foreach (VECS[k]) begin
         fmt_sel = VECS[k].fmt;
         wait_c(4);
         frame({VECS[k].word, 16'h0}, 16, got);
         check("R7 readback", 32'(got[31:16]), 32'(prev));
         check("R2 R4 commit", 32'(dac_code), 32'(VECS[k].exp));
         prev = VECS[k].exp;
      end

      // R2: wrong lengths discarded
      fmt_sel = 1'b1; wait_c(4);
      frame({16'h5555, 16'h0}, 15, got);
      check("R2 short frame", 32'(dac_code), 32'(prev));
      frame({16'h3333, 16'hFFFF}, 17, got);
      check("R2 long frame", 32'(dac_code), 32'(prev));

      // R5: hold then transfer
      ldac_n = 1'b1; wait_c(4);
      frame({16'hBEEF, 16'h0}, 16, got);
      check("R5 hold", 32'(dac_code), 32'(prev));
      ldac_n = 1'b0; wait_c(6);
      check("R5 transfer", 32'(dac_code), 32'hBEEF);

      // R3 R8: daisy chain
      sdo_src_sel = 1'b0; wait_c(4);
      frame({16'hC3A1, 16'h1E5D}, 32, got);
      check("R8 pass-through", 32'(got[15:0]), 32'hC3A1);
      check("R3 last word", 32'(dac_code), 32'h1E5D);
      frame({16'h0F0F, 16'h0}, 16, got);
      check("R3 exact word", 32'(dac_code), 32'h0F0F);
      n_chk++;
      if (sdo !== 1'bz) begin n_fail++; $display("FAIL R1 after frame actual=%b expected=z", sdo); end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule